// File: doc/BRIEF.md
# Sync-Hunting Receive Byte FIFO

This block sits behind a synchronous serial receiver that has already assembled whole bytes. After reset it hunts: every incoming byte is compared with a programmable sync code and thrown away until one matches. The matching byte itself is not stored, but from then on the block is locked and later bytes are queued for the host in a small FIFO. When strip mode is on, a locked receiver also throws away any byte equal to the sync code, so idle fill never reaches the host.

The host sees the oldest byte on a read port and removes it with a one-cycle pop strobe. A data-available flag tells the host when enough bytes are waiting. The threshold is one byte or two bytes, picked by a control input. A sticky overrun flag records a byte that arrived while the FIFO was full. A receiver-reset input flushes the queue and clears the status. A clear-sync input sends the block back to hunting.

Top module: `sync_rx_fifo`

## Requirements
- R1: After the asynchronous reset the FIFO is empty, `rda_o`, `overrun_o` and `in_sync_o` are 0, and `rd_data_o` is 0x00.
- R2: While not locked, a byte on `rx_valid_i` that differs from `sync_code_i` is discarded. A byte equal to it sets `in_sync_o` on the next cycle and is not queued.
- R3: While locked, accepted bytes are queued in arrival order. `rd_data_o` shows the oldest queued byte, and a `pop_i` cycle removes it.
- R4: While locked with `strip_sync_i` high, a byte equal to `sync_code_i` is discarded. With `strip_sync_i` low it is queued like any other byte.
- R5: The FIFO holds at most DEPTH (default 3) bytes. A byte arriving while it is full and not being popped is not stored, and `overrun_o` goes high and stays high until a receiver reset.
- R6: The threshold is 1 when `one_byte_thr_i` is 1 and 2 when it is 0. `rda_o` is 1 exactly when occupancy is at or above the threshold. A change of `one_byte_thr_i` takes effect on `rda_o` in the same cycle.
- R7: While `rx_reset_i` is high, incoming bytes and pops are ignored. The FIFO is emptied and `overrun_o` is cleared on the next edge. The lock state is kept.
- R8: While `clr_sync_i` is high, incoming bytes are ignored and `in_sync_o` clears on the next edge. Hunting then resumes.
- R9: A pop on an empty FIFO has no effect, and `rd_data_o` stays 0x00.
- R10: When a byte is accepted in the same cycle as a pop, the pop is taken first. On a full FIFO this keeps occupancy at DEPTH, stores the new byte and leaves `overrun_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | An assembled byte is present on `rx_data_i` |
| rx_data_i | input | DATA_W | Received byte |
| sync_code_i | input | DATA_W | Programmed sync code |
| rx_reset_i | input | 1 | Receiver reset: flush and clear status |
| clr_sync_i | input | 1 | Drop lock and return to hunting |
| strip_sync_i | input | 1 | Discard sync bytes once locked |
| one_byte_thr_i | input | 1 | 1: one-byte threshold, 0: two-byte threshold |
| pop_i | input | 1 | Host removes the oldest byte |
| rd_data_o | output | DATA_W | Oldest queued byte, 0 when empty |
| rda_o | output | 1 | Occupancy at or above threshold |
| overrun_o | output | 1 | Sticky overrun |
| in_sync_o | output | 1 | Locked to the sync code |

## Verification
The bench uses the default DATA_W of 8 and DEPTH of 3. With a depth of three, the full and overrun cases are three pushes away, so the table walk can step through fill, overflow, pop-while-pushing and drain in a few cycles. Both thresholds lie below the depth, so toggling the threshold select with one byte queued flips the data-available flag. That shows the same-cycle re-evaluation.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOCK = 2'd1,
    ACT_PUSH = 2'd2
  } rx_act_e;
endpackage

// File: rtl/sync_rx_filter.sv
module sync_rx_filter
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] sync_code_i,
  input  logic              rx_reset_i,
  input  logic              clr_sync_i,
  input  logic              strip_sync_i,
  output logic              push_o,
  output logic              in_sync_o
);
  rx_act_e act;
  logic    in_sync_q;
  logic    match;

  assign match = (data_i == sync_code_i);

  always_comb begin
    act = ACT_NONE;
    if (valid_i && !rx_reset_i && !clr_sync_i) begin
      if (!in_sync_q)                 act = match ? ACT_LOCK : ACT_NONE;
      else if (strip_sync_i && match) act = ACT_NONE;
      else                            act = ACT_PUSH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               in_sync_q <= 1'b0;
    else if (clr_sync_i)       in_sync_q <= 1'b0;
    else if (act == ACT_LOCK)  in_sync_q <= 1'b1;
  end

  assign push_o    = (act == ACT_PUSH);
  assign in_sync_o = in_sync_q;

  // R2: nothing is queued while hunting
  a_r2_hunt_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sync_q |-> !push_o);
  // R2: a matching byte while hunting locks
  a_r2_match_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_sync_q && valid_i && match && !rx_reset_i && !clr_sync_i) |=> in_sync_q);
  // R8: clear-sync drops lock
  a_r8_clear_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_sync_i |=> !in_sync_q);
  // R4: stripped sync byte never pushed
  a_r4_strip_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strip_sync_i && match) |-> !push_o);
endmodule

// File: rtl/sync_rx_store.sv
module sync_rx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [DATA_W-1:0]            push_data_i,
  output logic [DATA_W-1:0]            head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         overrun_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              ovr_q;
  logic              pop_en, wr_en, blocked;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  // pop is taken ahead of a same-cycle push
  assign pop_en  = pop_i && !flush_i && (count_q != '0);
  assign blocked = (count_q == FULL) && !pop_en;
  assign wr_en   = push_i && !flush_i && !blocked;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[i] <= '0;
      else if (wr_en && wr_ptr_q == PTR_W'(i))    mem_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (pop_en) rd_ptr_q <= inc(rd_ptr_q);
      if (wr_en)  wr_ptr_q <= inc(wr_ptr_q);
      count_q <= count_q + CNT_W'(wr_en) - CNT_W'(pop_en);
      if (push_i && blocked) ovr_q <= 1'b1;
    end
  end

  assign head_o    = (count_q != '0) ? mem_q[rd_ptr_q] : '0;
  assign count_o   = count_q;
  assign overrun_o = ovr_q;

  // R5: occupancy bounded
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL);
  // R5: overrun only rises from a push into a full FIFO
  a_r5_overrun_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> ($past(count_q) == FULL && $past(push_i)));
  // R9: pop on empty is harmless
  a_r9_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && count_q == '0) |=> (count_q == '0));
  // R10: push with pop on full keeps level, no new overrun
  a_r10_push_pop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && count_q == FULL) |=> (count_q == FULL && $stable(ovr_q)));
  // R7: flush empties and clears overrun
  a_r7_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && !ovr_q));
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [DATA_W-1:0] sync_code_i,
  input  logic              rx_reset_i,
  input  logic              clr_sync_i,
  input  logic              strip_sync_i,
  input  logic              one_byte_thr_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rda_o,
  output logic              overrun_o,
  output logic              in_sync_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             push;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] thr;

  sync_rx_filter #(.DATA_W(DATA_W)) u_filter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (rx_valid_i),
    .data_i       (rx_data_i),
    .sync_code_i  (sync_code_i),
    .rx_reset_i   (rx_reset_i),
    .clr_sync_i   (clr_sync_i),
    .strip_sync_i (strip_sync_i),
    .push_o       (push),
    .in_sync_o    (in_sync_o)
  );

  sync_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (rx_reset_i),
    .push_i      (push),
    .pop_i       (pop_i),
    .push_data_i (rx_data_i),
    .head_o      (rd_data_o),
    .count_o     (count),
    .overrun_o   (overrun_o)
  );

  // threshold follows the select input combinationally
  assign thr   = one_byte_thr_i ? CNT_W'(1) : CNT_W'(2);
  assign rda_o = (count >= thr);

  // R6: flag never up on an empty FIFO
  a_r6_rda_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> !rda_o);
  // R3: a push in a locked state grows occupancy unless popping or full
  a_r3_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop_i && !rx_reset_i && count < CNT_W'(DEPTH)) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: tb/sync_rx_fifo_tb_top.sv
module sync_rx_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] sync_code = 8'h7E;
  logic       rx_reset = 1'b0;
  logic       clr_sync = 1'b0;
  logic       strip = 1'b0;
  logic       one_thr = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] rd_data;
  logic       rda, ovr, in_sync;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_rx_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .sync_code_i(sync_code), .rx_reset_i(rx_reset), .clr_sync_i(clr_sync),
    .strip_sync_i(strip), .one_byte_thr_i(one_thr), .pop_i(pop),
    .rd_data_o(rd_data), .rda_o(rda), .overrun_o(ovr), .in_sync_o(in_sync)
  );

  // {valid, data, pop, exp_rda, exp_ovr, exp_sync, exp_head}; sync=7E, thr=2, no strip
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 hunt drop
    {1'b1, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00},  // R2 lock, not queued
    {1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA1},  // R3, R6 one < thr 2
    {1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA1},  // R4 sync kept, R6
    {1'b1, 8'hB2, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA1},  // R3 full
    {1'b1, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA1},  // R5 overrun
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E},  // R3 pop
    {1'b1, 8'hD4, 1'b1, 1'b1, 1'b1, 1'b1, 8'hB2},  // R10 pop+push
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hD4},  // R6 drop below thr
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},  // R3 drained
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00}   // R9 pop empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive after the edge, clock once, outputs settled 1 ns later
  task automatic cyc(input logic v, input logic [7:0] d, input logic p);
    rx_valid = v; rx_data = d; pop = p;
    @(posedge clk); #1;
    rx_valid = 1'b0; pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #5;
    chk("R1 head", 32'(rd_data), 32'h00);
    chk("R1 flags", {29'b0, rda, ovr, in_sync}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][20], VEC[i][19:12], VEC[i][11]);
      chk($sformatf("R3 vec%0d head", i), 32'(rd_data), 32'(VEC[i][7:0]));
      chk($sformatf("R6 vec%0d rda", i), 32'(rda), 32'(VEC[i][10]));
      chk($sformatf("R5 vec%0d ovr", i), 32'(ovr), 32'(VEC[i][9]));
      chk($sformatf("R2 vec%0d sync", i), 32'(in_sync), 32'(VEC[i][8]));
    end

    // R7: receiver reset clears overrun, ignores byte, keeps lock
    rx_reset = 1'b1;
    cyc(1'b1, 8'h55, 1'b1);
    rx_reset = 1'b0;
    chk("R7 ovr", 32'(ovr), 32'h0);
    chk("R7 head", 32'(rd_data), 32'h00);
    chk("R7 sync kept", 32'(in_sync), 32'h1);

    // R6: threshold change re-evaluated in same cycle
    cyc(1'b1, 8'h21, 1'b0);
    chk("R6 thr2 one byte", 32'(rda), 32'h0);
    one_thr = 1'b1; #1;
    chk("R6 thr1 one byte", 32'(rda), 32'h1);
    one_thr = 1'b0; #1;
    chk("R6 thr back", 32'(rda), 32'h0);

    // R4: strip on drops sync byte
    strip = 1'b1;
    cyc(1'b1, 8'h7E, 1'b0);
    cyc(1'b1, 8'h22, 1'b0);
    chk("R4 head", 32'(rd_data), 32'h21);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R4 second", 32'(rd_data), 32'h22);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R4 empty", 32'(rd_data), 32'h00);
    strip = 1'b0;

    // R10: full FIFO, push with pop
    cyc(1'b1, 8'h31, 1'b0);
    cyc(1'b1, 8'h32, 1'b0);
    cyc(1'b1, 8'h33, 1'b0);
    cyc(1'b1, 8'h34, 1'b1);
    chk("R10 ovr", 32'(ovr), 32'h0);
    chk("R10 head", 32'(rd_data), 32'h32);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R10 next", 32'(rd_data), 32'h33);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R10 new byte", 32'(rd_data), 32'h34);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R9 drained", 32'(rd_data), 32'h00);

    // R8: clear-sync returns to hunting, bytes ignored meanwhile
    clr_sync = 1'b1;
    cyc(1'b1, 8'h7E, 1'b0);
    clr_sync = 1'b0;
    chk("R8 unlocked", 32'(in_sync), 32'h0);
    cyc(1'b1, 8'h44, 1'b0);
    chk("R8 hunt drop", 32'(rd_data), 32'h00);
    cyc(1'b1, 8'h7E, 1'b0);
    chk("R8 relock", 32'(in_sync), 32'h1);
    chk("R2 sync not queued", 32'(rd_data), 32'h00);
    cyc(1'b1, 8'h45, 1'b0);
    chk("R3 after relock", 32'(rd_data), 32'h45);

    finish_run();
  end
endmodule